// File: doc/BRIEF.md
# Five-Source Prioritised Interrupt Recogniser

This block decides, for a small 8-bit processor core, whether an interrupt is taken at the end of the current instruction and which one. It watches five request lines:

- a non-maskable request;
- three maskable requests that each have a fixed vector;
- one general request with no vector.

Each line follows its own triggering rule. The non-maskable line needs a rising edge, and the line must still be high when it is sampled. The highest maskable line is captured on a rising edge into a flip-flop. The two lower maskable lines are level-sensitive. The block resolves them in a fixed priority and gates them with per-line masks and a global enable flip-flop.

The core pulses `insn_end` when an instruction completes. If a request wins at that point, the block reports it in the next cycle, for one cycle. A vectored request drives `vec_valid` with a 16-bit call address. The general request instead pulls the active-low `inta_n` low, and external logic then supplies an opcode. The core does the stacking and the jump itself.

A mask-write port sets the masks, clears the edge flip-flop and loads a serial output latch. A combinational status word returns the serial input pin, the pending lines, the enable flag and the masks.

Top module: `irq_recog5`

## Requirements
- R1: After reset the masks read 1, the enable flag reads 0, the edge flip-flop is clear, `ser_out` is 0, `vec_valid` is 0 and `inta_n` is 1. The status word therefore reads 8'h07 when `ser_in` and all level lines are 0.
- R2: Priority from highest to lowest is non-maskable (vector 16'h0024), edge line `r75_req` (16'h003C), level line `r65_req` (16'h0034), level line `r55_req` (16'h002C), then general `gen_req`, which has no vector. `vec_addr` is 0 when `vec_valid` is 0.
- R3: The non-maskable request ignores the masks and the enable flag. It is taken only when a rising edge has been seen and the line is still high at the boundary. After being taken it is not taken again until the line has gone low and risen again.
- R4: A rising edge on `r75_req` sets a flip-flop regardless of the mask. The flip-flop holds after the line falls and clears when that request is taken or when a mask write has bit 4 set.
- R5: `r65_req` and `r55_req` are sampled as levels at the boundary.
- R6: A request is taken only in a cycle with `insn_end` high. The result appears in the following cycle for exactly one cycle: `vec_valid` high with `vec_addr` for a vectored source, or `inta_n` low for the general source.
- R7: `ei_pulse` sets the enable flag. `di_pulse`, reset and the taking of any request clear it, and a clear wins over a set in the same cycle. The three maskable lines and the general line are taken only while the flag is 1.
- R8: In a mask write, bits 2, 1 and 0 mask the edge line, `r65_req` and `r55_req` respectively, and a 1 masks. They load only when bit 3 is 1.
- R9: In a mask write, bit 7 loads the `ser_out` latch only when bit 6 is 1.
- R10: `mask_rdata` is {`ser_in`, edge flip-flop, `r65_req`, `r55_req`, enable flag, mask of edge line, mask of `r65_req`, mask of `r55_req`}, bit 7 down to bit 0.
- R11: A lower-priority request that arrives with or during a higher one stays pending and is taken at a later boundary once enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Non-maskable request |
| r75_req | input | 1 | Edge-captured maskable request |
| r65_req | input | 1 | Level maskable request, middle priority |
| r55_req | input | 1 | Level maskable request, low priority |
| gen_req | input | 1 | General non-vectored request |
| insn_end | input | 1 | Instruction boundary strobe |
| ei_pulse | input | 1 | Set enable flag |
| di_pulse | input | 1 | Clear enable flag |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | Mask write data |
| ser_in | input | 1 | Serial input pin |
| mask_rdata | output | 8 | Status word |
| ser_out | output | 1 | Serial output latch |
| vec_valid | output | 1 | Vectored request taken |
| vec_addr | output | 16 | Call address |
| inta_n | output | 1 | Active-low acknowledge for the general request |

## Verification
On every cycle, the assertions check the following:
- an acceptance follows a boundary strobe;
- the enable flag is clear whenever an acceptance is reported;
- a non-maskable vector appears only when that line was high at the boundary;
- a mask write without bit 3 leaves the masks unchanged.

Priority resolution is checked by a sweep over all 32 request patterns under all 8 mask settings. Directed scenarios cover the behaviours that depend on history:
- edge latching that survives the line dropping;
- re-arming of the non-maskable input;
- retained lower-priority requests;
- the serial latch gating.

// File: rtl/irq_recog5.sv
module irq_recog5 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nmi_req,
  input  logic        r75_req,
  input  logic        r65_req,
  input  logic        r55_req,
  input  logic        gen_req,
  input  logic        insn_end,
  input  logic        ei_pulse,
  input  logic        di_pulse,
  input  logic        mask_wr,
  input  logic [7:0]  mask_wdata,
  input  logic        ser_in,
  output logic [7:0]  mask_rdata,
  output logic        ser_out,
  output logic        vec_valid,
  output logic [15:0] vec_addr,
  output logic        inta_n
);

  logic       nmi_d, r75_d, nmi_pend, r75_ff, ie_q;
  logic [2:0] mask_q;

  wire nmi_rise = nmi_req & ~nmi_d;
  wire r75_rise = r75_req & ~r75_d;

  wire c_nmi = nmi_pend & nmi_req;
  wire c_75  = ie_q & r75_ff  & ~mask_q[2];
  wire c_65  = ie_q & r65_req & ~mask_q[1];
  wire c_55  = ie_q & r55_req & ~mask_q[0];
  wire c_gen = ie_q & gen_req;

  wire take   = insn_end & (c_nmi | c_75 | c_65 | c_55 | c_gen);
  wire tk_nmi = insn_end & c_nmi;
  wire tk_75  = insn_end & c_75 & ~c_nmi;

  logic [15:0] win_addr;
  logic        win_vec;

  always_comb begin
    win_vec  = 1'b1;
    win_addr = 16'h0000;
    if (c_nmi)      win_addr = 16'h0024;
    else if (c_75)  win_addr = 16'h003C;
    else if (c_65)  win_addr = 16'h0034;
    else if (c_55)  win_addr = 16'h002C;
    else            win_vec  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_d     <= 1'b0;
      r75_d     <= 1'b0;
      nmi_pend  <= 1'b0;
      r75_ff    <= 1'b0;
      ie_q      <= 1'b0;
      mask_q    <= 3'b111;
      ser_out   <= 1'b0;
      vec_valid <= 1'b0;
      vec_addr  <= 16'h0000;
      inta_n    <= 1'b1;
    end else begin
      nmi_d    <= nmi_req;
      r75_d    <= r75_req;
      nmi_pend <= nmi_rise | (nmi_pend & nmi_req & ~tk_nmi);
      r75_ff   <= r75_rise | (r75_ff & ~tk_75 & ~(mask_wr & mask_wdata[4]));
      if (take || di_pulse) ie_q <= 1'b0;
      else if (ei_pulse)    ie_q <= 1'b1;
      if (mask_wr && mask_wdata[3]) mask_q  <= mask_wdata[2:0];
      if (mask_wr && mask_wdata[6]) ser_out <= mask_wdata[7];
      vec_valid <= take & win_vec;
      vec_addr  <= (take & win_vec) ? win_addr : 16'h0000;
      inta_n    <= ~(take & ~win_vec);
    end
  end

  assign mask_rdata = {ser_in, r75_ff, r65_req, r55_req, ie_q, mask_q};

  // R6
  accept_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid || !inta_n) |-> $past(insn_end));

  // R7
  ie_clear_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid || !inta_n) |-> !ie_q);

  // R3
  nmi_held_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_addr == 16'h0024) |-> $past(nmi_req));

  // R8
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !mask_wdata[3]) |=> $stable(mask_q));

endmodule

// File: tb/test_irq_recog5.sv
module test_irq_recog5;
  logic clk = 1'b0;
  logic rst_n;
  logic nmi_req, r75_req, r65_req, r55_req, gen_req;
  logic insn_end, ei_pulse, di_pulse, mask_wr, ser_in;
  logic [7:0] mask_wdata, mask_rdata;
  logic ser_out, vec_valid, inta_n;
  logic [15:0] vec_addr;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_recog5 i_irq_recog5 (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .r75_req(r75_req),
    .r65_req(r65_req), .r55_req(r55_req), .gen_req(gen_req),
    .insn_end(insn_end), .ei_pulse(ei_pulse), .di_pulse(di_pulse),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .ser_in(ser_in),
    .mask_rdata(mask_rdata), .ser_out(ser_out), .vec_valid(vec_valid),
    .vec_addr(vec_addr), .inta_n(inta_n));

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_acc(input string tag, input logic ev, input logic [15:0] ea, input logic ei);
    checks++;
    if (vec_valid !== ev || vec_addr !== ea || inta_n !== ei) begin
      errors++;
      $display("FAIL %s actual=%b/%h/%b expected=%b/%h/%b", tag,
               vec_valid, vec_addr, inta_n, ev, ea, ei);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {nmi_req, r75_req, r65_req, r55_req, gen_req} = '0;
    {insn_end, ei_pulse, di_pulse, mask_wr, ser_in} = '0;
    mask_wdata = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic boundary();
    insn_end = 1'b1;
    @(negedge clk);
    insn_end = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    mask_wr = 1'b1;
    mask_wdata = d;
    @(negedge clk);
    mask_wr = 1'b0;
  endtask

  task automatic pulse_ei();
    ei_pulse = 1'b1;
    @(negedge clk);
    ei_pulse = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 and R10: reset state and status layout
    do_reset();
    @(negedge clk);
    chk_acc("R1 idle outputs", 1'b0, 16'h0, 1'b1);
    chk8("R1 status after reset", mask_rdata, 8'h07);
    chk8("R1 ser_out after reset", {7'b0, ser_out}, 8'h00);
    ser_in = 1'b1; r65_req = 1'b1;
    #1;
    chk8("R10 status with ser_in and r65", mask_rdata, 8'hA7);
    ser_in = 1'b0; r65_req = 1'b0;

    // R2 and R8: sweep of every request pattern under every mask
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 32; p++) begin
        logic [15:0] ea;
        logic ev, ei;
        do_reset();
        ei_pulse = 1'b1; mask_wr = 1'b1; mask_wdata = 8'h08 | m[7:0];
        nmi_req = p[4]; r75_req = p[3]; r65_req = p[2]; r55_req = p[1]; gen_req = p[0];
        @(negedge clk);
        ei_pulse = 1'b0; mask_wr = 1'b0;
        ev = 1'b1; ei = 1'b1; ea = 16'h0;
        if (p[4]) ea = 16'h0024;
        else if (p[3] && !m[2]) ea = 16'h003C;
        else if (p[2] && !m[1]) ea = 16'h0034;
        else if (p[1] && !m[0]) ea = 16'h002C;
        else begin ev = 1'b0; ei = !p[0]; end
        boundary();
        chk_acc($sformatf("R2 R8 sweep m=%0d p=%0d", m, p), ev, ea, ei);
      end
    end

    // R3: non-maskable ignores enable, no re-take while held, re-arms after low
    do_reset();
    nmi_req = 1'b1;
    @(negedge clk);
    boundary();
    chk_acc("R3 nmi with enable off", 1'b1, 16'h0024, 1'b1);
    pulse_ei();
    boundary();
    chk_acc("R3 no re-take while held", 1'b0, 16'h0, 1'b1);
    nmi_req = 1'b0;
    @(negedge clk);
    nmi_req = 1'b1;
    @(negedge clk);
    boundary();
    chk_acc("R3 re-armed after low", 1'b1, 16'h0024, 1'b1);
    do_reset();
    nmi_req = 1'b1;
    @(negedge clk);
    nmi_req = 1'b0;
    boundary();
    chk_acc("R3 edge without held level", 1'b0, 16'h0, 1'b1);

    // R4: edge flip-flop latches while masked, cleared by bit 4 and by taking
    do_reset();
    r75_req = 1'b1;
    @(negedge clk);
    r75_req = 1'b0;
    chk8("R4 latched while masked", {7'b0, mask_rdata[6]}, 8'h01);
    wr(8'h10);
    chk8("R4 software clear", {7'b0, mask_rdata[6]}, 8'h00);
    r75_req = 1'b1;
    @(negedge clk);
    r75_req = 1'b0;
    wr(8'h08);
    pulse_ei();
    boundary();
    chk_acc("R4 taken after line fell", 1'b1, 16'h003C, 1'b1);
    chk8("R4 cleared on take", {7'b0, mask_rdata[6]}, 8'h00);

    // R5 and R6: levels not taken without a boundary strobe
    do_reset();
    wr(8'h08);
    pulse_ei();
    r55_req = 1'b1;
    begin
      int seen = 0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (vec_valid || !inta_n) seen++;
      end
      chk8("R6 nothing without insn_end", seen[7:0], 8'h00);
    end
    boundary();
    chk_acc("R5 level line taken", 1'b1, 16'h002C, 1'b1);
    @(negedge clk);
    chk_acc("R6 one-cycle report", 1'b0, 16'h0, 1'b1);

    // R7: disable, simultaneous set/clear, general request acknowledge
    do_reset();
    wr(8'h08);
    r55_req = 1'b1;
    pulse_ei();
    di_pulse = 1'b1;
    @(negedge clk);
    di_pulse = 1'b0;
    boundary();
    chk_acc("R7 disabled blocks maskable", 1'b0, 16'h0, 1'b1);
    chk8("R7 flag after di", {7'b0, mask_rdata[3]}, 8'h00);
    ei_pulse = 1'b1; di_pulse = 1'b1;
    @(negedge clk);
    ei_pulse = 1'b0; di_pulse = 1'b0;
    chk8("R7 clear wins over set", {7'b0, mask_rdata[3]}, 8'h00);
    r55_req = 1'b0;
    gen_req = 1'b1;
    pulse_ei();
    boundary();
    chk_acc("R7 general acknowledge", 1'b0, 16'h0, 1'b0);
    chk8("R7 flag cleared on take", {7'b0, mask_rdata[3]}, 8'h00);
    @(negedge clk);
    chk_acc("R7 acknowledge released", 1'b0, 16'h0, 1'b1);
    gen_req = 1'b0;

    // R8: mask load gating
    wr(8'h0D);
    chk8("R8 masks loaded", {5'b0, mask_rdata[2:0]}, 8'h05);
    wr(8'h02);
    chk8("R8 masks kept without bit 3", {5'b0, mask_rdata[2:0]}, 8'h05);

    // R9: serial output latch
    wr(8'h80);
    chk8("R9 no load without bit 6", {7'b0, ser_out}, 8'h00);
    wr(8'hC0);
    chk8("R9 load one", {7'b0, ser_out}, 8'h01);
    wr(8'h40);
    chk8("R9 load zero", {7'b0, ser_out}, 8'h00);

    // R11: lower request retained across a higher one
    do_reset();
    wr(8'h08);
    pulse_ei();
    r75_req = 1'b1; r65_req = 1'b1;
    @(negedge clk);
    r75_req = 1'b0;
    boundary();
    chk_acc("R11 higher taken first", 1'b1, 16'h003C, 1'b1);
    chk8("R11 pending bits", {5'b0, mask_rdata[6:4]}, 8'h02);
    pulse_ei();
    boundary();
    chk_acc("R11 lower taken later", 1'b1, 16'h0034, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule